// File: doc/BRIEF.md
# Manchester Transmit Frame Generator

This block turns a parallel data word into a framed, Manchester-coded level sequence on one output wire. It is meant to drive the keying input of an on/off-keyed radio. A pulse on the start input while the block is idle captures the word. The block then plays out a frame. The frame opens with a long high run, which lets the far-end receiver lock on, followed by one low period. Next come two line symbols per data bit, least significant bit first. The frame closes with a fixed four-symbol trailer. Every symbol lasts the same programmable number of clock cycles.

The controller has six states. IDLE waits for a start strobe and holds the line low. PRE_HIGH drives the line high for four bit periods. PRE_LOW drives it low for one bit period. DATA_A sends the first half of the current bit: high for a 0, low for a 1. DATA_B sends the second half, which is the bit value itself. TRAILER sends low, high, low, high.

The transitions are:
- IDLE to PRE_HIGH on an accepted start.
- PRE_HIGH to PRE_LOW at the end of its fourth period.
- PRE_LOW to DATA_A.
- DATA_A to DATA_B.
- DATA_B back to DATA_A while bits remain, otherwise to TRAILER.
- TRAILER to IDLE after its fourth symbol. This step raises the done pulse.

A synchronous reset forces IDLE from any state.

Top module: `mtx_frame_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, line_o, busy_o and done_o are all 0.
- R2: A frame starts with four bit periods of line high, then one bit period of line low.
- R3: Each data bit is sent as two symbols. A 0 is sent as high then low, and a 1 as low then high.
- R4: Data bits leave least significant first. Word 4'b1000 therefore produces the symbols 10 10 10 01.
- R5: After the last data symbol the line carries low, high, low, high, one bit period each.
- R6: Every symbol lasts exactly BIT_CYC clock cycles. busy_o stays high for (9 + 2*WORD_W)*BIT_CYC consecutive cycles per frame. busy_o rises in the cycle after the start edge.
- R7: done_o is high for exactly one cycle. That cycle immediately follows the last trailer symbol, and busy_o is low in it.
- R8: A start strobe that arrives while busy_o is high has no effect on the frame in flight.
- R9: The word is captured when start is accepted. Later changes on word_i do not alter the frame being sent.
- R10: A start presented in the cycle where done_o is high is accepted. The new frame's preamble begins in the next cycle, with no further idle cycle.
- R11: Whenever busy_o is low, line_o is low.
- R12: A reset applied in the middle of a frame aborts it. busy_o and line_o are low in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, accepted only while idle |
| word_i | input | WORD_W | Data word to transmit |
| line_o | output | 1 | Coded serial line level |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse after the final trailer symbol |

## Verification
The done pulse and the acceptance of a new start can coincide. In the single cycle where done_o is high, the controller is already in IDLE, so a start held at that moment must launch the next frame straight away. The bench waits for done_o, raises start before the next rising edge, and queues the second frame's symbols behind the first. The scoreboard then requires one idle cycle carrying the done pulse, followed at once by the new preamble, with every symbol still exactly BIT_CYC cycles long.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PRE_HIGH = 3'd1,
        ST_PRE_LOW  = 3'd2,
        ST_DATA_A   = 3'd3,
        ST_DATA_B   = 3'd4,
        ST_TRAILER  = 3'd5
    } mtx_state_e;

    localparam int PRE_HIGH_SYMS = 4;
    localparam int TRAILER_SYMS  = 4;
endpackage

// File: rtl/mtx_bit_timer.sv
module mtx_bit_timer #(
    parameter int BIT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    generate
        if (BIT_CYC > 1) begin : g_spacing
            // R6
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/mtx_word_reg.sv
module mtx_word_reg #(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              lsb
);
    logic [WORD_W-1:0] q;

    assign lsb = q[0];

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= din;
        else if (shift) q <= {1'b0, q[WORD_W-1:1]};
    end

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));
endmodule

// File: rtl/mtx_frame_gen.sv
module mtx_frame_gen #(
    parameter int WORD_W  = 4,
    parameter int BIT_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              line_o,
    output logic              busy_o,
    output logic              done_o
);
    import mtx_pkg::*;

    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [1:0] LAST_PRE = 2'(PRE_HIGH_SYMS - 1);
    localparam logic [1:0] LAST_TRL = 2'(TRAILER_SYMS - 1);

    mtx_state_e       state, state_n;
    logic [1:0]       sym_cnt, sym_cnt_n;
    logic [IDX_W-1:0] bit_idx, bit_idx_n;
    logic             done_n;
    logic             tick, accept, shift, cur_bit;

    assign accept = (state == ST_IDLE) && start_i;
    assign shift  = tick && (state == ST_DATA_B);

    mtx_bit_timer #(.BIT_CYC(BIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .tick (tick)
    );

    mtx_word_reg #(.WORD_W(WORD_W)) u_word (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (shift),
        .din   (word_i),
        .lsb   (cur_bit)
    );

    // next-state logic
    always_comb begin
        state_n   = state;
        sym_cnt_n = sym_cnt;
        bit_idx_n = bit_idx;
        done_n    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    state_n   = ST_PRE_HIGH;
                    sym_cnt_n = '0;
                    bit_idx_n = '0;
                end
            end
            ST_PRE_HIGH: begin
                if (tick) begin
                    if (sym_cnt == LAST_PRE) begin
                        state_n   = ST_PRE_LOW;
                        sym_cnt_n = '0;
                    end else begin
                        sym_cnt_n = sym_cnt + 1'b1;
                    end
                end
            end
            ST_PRE_LOW: begin
                if (tick) state_n = ST_DATA_A;
            end
            ST_DATA_A: begin
                if (tick) state_n = ST_DATA_B;
            end
            ST_DATA_B: begin
                if (tick) begin
                    if (bit_idx == LAST_IDX) begin
                        state_n   = ST_TRAILER;
                        sym_cnt_n = '0;
                    end else begin
                        state_n   = ST_DATA_A;
                        bit_idx_n = bit_idx + 1'b1;
                    end
                end
            end
            ST_TRAILER: begin
                if (tick) begin
                    if (sym_cnt == LAST_TRL) begin
                        state_n   = ST_IDLE;
                        sym_cnt_n = '0;
                        done_n    = 1'b1;
                    end else begin
                        sym_cnt_n = sym_cnt + 1'b1;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sym_cnt <= '0;
            bit_idx <= '0;
            done_o  <= 1'b0;
        end else begin
            state   <= state_n;
            sym_cnt <= sym_cnt_n;
            bit_idx <= bit_idx_n;
            done_o  <= done_n;
        end
    end

    // output decode
    always_comb begin
        busy_o = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:     line_o = 1'b0;
            ST_PRE_HIGH: line_o = 1'b1;
            ST_PRE_LOW:  line_o = 1'b0;
            ST_DATA_A:   line_o = ~cur_bit;
            ST_DATA_B:   line_o = cur_bit;
            ST_TRAILER:  line_o = sym_cnt[0];
            default:     line_o = 1'b0;
        endcase
    end

    // R11
    idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !line_o);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !tick) |=> busy_o);
    // R10
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (busy_o && line_o));
endmodule

// File: tb/mtx_frame_gen_test.sv
`timescale 1ns/1ps
module mtx_frame_gen_test;
    localparam int WORD_W  = 4;
    localparam int BIT_CYC = 8;
    localparam int FRAME_CYC = (9 + 2 * WORD_W) * BIT_CYC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [WORD_W-1:0] word_i = '0;
    logic line_o, busy_o, done_o;

    int total = 0;
    int bad = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    mtx_frame_gen #(.WORD_W(WORD_W), .BIT_CYC(BIT_CYC)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic push(input bit lvl, input string req);
        exp_q.push_back(lvl);
        tag_q.push_back(req);
    endtask

    // driver: queues the expected symbols, then strobes start
    task automatic send(input logic [WORD_W-1:0] w);
        for (int i = 0; i < 4; i++) push(1'b1, "R2");
        push(1'b0, "R2");
        for (int i = 0; i < WORD_W; i++) begin
            push(~w[i], (i == 0) ? "R4" : "R3");
            push(w[i], "R3");
        end
        push(1'b0, "R5"); push(1'b1, "R5"); push(1'b0, "R5"); push(1'b1, "R5");
        word_i  = w;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done_o);
        #1;
    endtask

    // monitor / scoreboard
    int  cyc = 0;
    int  busy_len = 0;
    bit  prev_busy = 0;
    bit  prev_done = 0;
    always @(negedge clk) begin
        if (rst) begin
            cyc = 0; busy_len = 0; prev_busy = 0; prev_done = 0;
        end else begin
            if (busy_o) begin
                busy_len++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", 1, 0);
                end else begin
                    check(line_o == exp_q[0], tag_q[0], line_o, exp_q[0]);
                    cyc++;
                    if (cyc == BIT_CYC) begin
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                        cyc = 0;
                    end
                end
            end else begin
                check(line_o == 1'b0, "R11", line_o, 0);
            end
            if (prev_busy && !busy_o) begin
                check(done_o == 1'b1, "R7", done_o, 1);
                check(exp_q.size() == 0, "R6", exp_q.size(), 0);
                check(busy_len == FRAME_CYC, "R6", busy_len, FRAME_CYC);
                busy_len = 0;
            end
            if (prev_done) check(done_o == 1'b0, "R7", done_o, 0);
            prev_busy = busy_o;
            prev_done = done_o;
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(line_o == 0 && busy_o == 0 && done_o == 0, "R1", {line_o, busy_o, done_o}, 0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(line_o == 0 && busy_o == 0 && done_o == 0, "R1", {line_o, busy_o, done_o}, 0);
        // R11: idle stays low
        repeat (5) @(posedge clk);
        #1;

        // R4: the worked example word
        send(4'b1000);
        check(busy_o == 1'b1, "R6", busy_o, 1);
        wait_done();
        repeat (3) @(posedge clk);
        #1;

        // R8 and R9: stray start and word change mid-frame
        send(4'b0101);
        repeat (20) @(posedge clk);
        #1;
        word_i = 4'b1110;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (40) @(posedge clk);
        #1;
        word_i = 4'b0000;
        wait_done();
        repeat (2) @(posedge clk);
        #1;

        // R10: back-to-back on the done cycle
        send(4'b1111);
        do @(negedge clk); while (!done_o);
        #1;
        send(4'b0000);
        check(busy_o == 1'b1, "R10", busy_o, 1);
        wait_done();
        repeat (2) @(posedge clk);
        #1;

        // R12: reset in mid-frame
        send(4'b0011);
        repeat (50) @(posedge clk);
        #1;
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        @(posedge clk); #1;
        check(busy_o == 0 && line_o == 0, "R12", {busy_o, line_o}, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(busy_o == 0 && done_o == 0, "R12", {busy_o, done_o}, 0);

        send(4'b0110);
        wait_done();
        repeat (3) @(posedge clk);
        #1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule